// File: doc/BRIEF.md
# Sideband Packet Stream-to-Packet Bridge

This block sits on the transmit side of a video link. It takes sideband packets such as infoframes and audio packets from a 32-bit AXI4-Stream source. It turns each one into a single parallel word set for the downstream data-island packet inserter. Arriving beats first enter a small synchronous FIFO. The source is therefore only throttled when that buffer is actually full.

A packet assembler drains the FIFO. Every transfer is nine beats long. The first beat is a header word, carrying three header bytes in bits [23:0] and their parity byte in bits [31:24]. Then come four 64-bit subpackets, each delivered as two beats with the low half first. The assembled packet is presented on a valid/ready handshake and held there until it is taken. Transfers whose tlast does not land on the ninth beat are thrown away, and a one-cycle framing-error pulse is raised.

Top module: `sbp_bridge`

## Requirements
- R1: `s_tready` is high exactly when the FIFO holds fewer than `DEPTH` beats (default 16); with the assembler stalled, it falls after the FIFO has taken `DEPTH` beats.
- R2: A beat is taken only on a clock edge where `s_tvalid` and `s_tready` are both high, and beats leave the FIFO in arrival order, whatever gaps occur in `s_tvalid`.
- R3: `pkt_header` equals the first beat of the transfer, bit for bit (header bytes in [23:0], parity byte in [31:24], unchanged).
- R4: Subpacket k (k = 0..3, on `pkt_sub0`..`pkt_sub3`) is beat 2k+2 in bits [31:0] and beat 2k+3 in bits [63:32], counting beats from 1. Its seven data bytes in [55:0] and its parity byte in [63:56] are passed unchanged.
- R5: `pkt_valid` rises the cycle after the ninth beat leaves the FIFO. It then stays high, with header and subpackets stable, until a cycle with `pkt_ready` high. No beat leaves the FIFO while `pkt_valid` is high.
- R6: If tlast arrives on beat 1 to 8, the beats collected so far are discarded and `frame_err` is high for the single following cycle. The next beat starts a new packet.
- R7: If the ninth beat lacks tlast, `frame_err` pulses once and no packet is produced. Every later beat up to and including the next tlast is dropped, and the beat after it starts a new packet.
- R8: After reset, `pkt_valid` and `frame_err` are low and `s_tready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_tdata | input | 32 | Stream beat data |
| s_tvalid | input | 1 | Stream beat valid |
| s_tlast | input | 1 | Marks the final beat of a transfer |
| s_tready | output | 1 | Bridge can accept a beat |
| pkt_valid | output | 1 | Assembled packet available |
| pkt_ready | input | 1 | Downstream takes the packet |
| pkt_header | output | 32 | Header word |
| pkt_sub0 | output | 64 | Subpacket 0 |
| pkt_sub1 | output | 64 | Subpacket 1 |
| pkt_sub2 | output | 64 | Subpacket 2 |
| pkt_sub3 | output | 64 | Subpacket 3 |
| frame_err | output | 1 | One-cycle pulse on a framing violation |

## Verification
The assertions check several properties on every cycle. They check that stream-ready follows an independently kept occupancy count. They check that the FIFO never overflows or pops when empty. They check that a pending packet holds its contents and blocks further pops. They check that a packet and a framing error never arise from the same beat. The byte placement of the header and subpackets, and the discard-and-resynchronise behaviour after early or missing tlast, only show up in the bench's scenarios. There, a behavioural model replays the stream and compares every output on every cycle.

// File: rtl/sbp_pkg.sv
// Package: shared geometry of a sideband packet transfer.
// Assumes a fixed layout of one header beat followed by subpackets,
// each subpacket split over a fixed number of stream beats.
package sbp_pkg;
    localparam int DATA_W        = 32;
    localparam int SUBPKTS       = 4;
    localparam int BEATS_PER_SUB = 2;
    localparam int SUB_W         = DATA_W * BEATS_PER_SUB;
    localparam int BEATS         = 1 + SUBPKTS * BEATS_PER_SUB;
    localparam int CNT_W         = $clog2(BEATS);

    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_DRAIN   = 2'd1,
        ST_HOLD    = 2'd2
    } asm_state_t;
endpackage

// File: rtl/sbp_fifo.sv
// Module: sbp_fifo
// Synchronous first-word-fall-through FIFO. The head entry is visible on
// rd_data while empty is low; rd_en pops it.
// Assumes DEPTH is a power of two, and that the user never writes when
// full or reads when empty (both are also gated here).
module sbp_fifo #(
    parameter int WIDTH = 33,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             full,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wr_ptr;
    logic [AW:0]      rd_ptr;
    logic             do_wr;
    logic             do_rd;

    // Gate requests against the buffer state.
    always_comb begin
        do_wr = wr_en && !full;
        do_rd = rd_en && !empty;
    end

    // Flag decode from the wrap-extended pointers.
    always_comb begin
        empty = (wr_ptr == rd_ptr);
        full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    end

    // Pointer advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr[AW-1:0]] <= wr_data;
    end

    // Head of queue is always presented.
    assign rd_data = mem[rd_ptr[AW-1:0]];
endmodule

// File: rtl/sbp_assembler.sv
// Module: sbp_assembler
// Pulls beats from the FIFO head and collects one transfer into a word
// buffer. It checks that tlast falls exactly on the final beat, and holds
// a finished packet until it is accepted.
// Assumes beats are presented first-word-fall-through (avail/data/last).
module sbp_assembler
    import sbp_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    beat_avail,
    input  logic [DATA_W-1:0]       beat_data,
    input  logic                    beat_last,
    output logic                    beat_take,
    output logic                    pkt_valid,
    input  logic                    pkt_ready,
    output logic                    frame_err,
    output logic [BEATS*DATA_W-1:0] words
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BEATS - 1);

    asm_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic             store;

    // Pop whenever a beat waits and no packet is pending.
    always_comb begin
        beat_take = beat_avail && (state != ST_HOLD);
        store     = beat_take && (state == ST_COLLECT);
        pkt_valid = (state == ST_HOLD);
    end

    // Framing state machine, beat counter and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_COLLECT;
            cnt       <= '0;
            frame_err <= 1'b0;
        end else begin
            frame_err <= 1'b0;
            unique case (state)
                ST_HOLD: begin
                    if (pkt_ready) state <= ST_COLLECT;
                end
                ST_DRAIN: begin
                    if (beat_take && beat_last) state <= ST_COLLECT;
                end
                default: begin
                    if (beat_take) begin
                        if (beat_last) begin
                            cnt <= '0;
                            if (cnt == LAST_IDX) state <= ST_HOLD;
                            else                 frame_err <= 1'b1;
                        end else if (cnt == LAST_IDX) begin
                            cnt       <= '0;
                            frame_err <= 1'b1;
                            state     <= ST_DRAIN;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // One capture register per beat slot.
    for (genvar i = 0; i < BEATS; i++) begin : g_slot
        // Capture the beat whose position matches this slot.
        always_ff @(posedge clk) begin
            if (store && (cnt == CNT_W'(i)))
                words[i*DATA_W +: DATA_W] <= beat_data;
        end
    end
endmodule

// File: rtl/sbp_packer.sv
// Module: sbp_packer
// Pure wiring: maps the collected beat words onto the header and the
// subpacket fields, the earlier beat of each subpacket in the low half.
// Assumes words holds beat 0 in the lowest DATA_W bits.
module sbp_packer
    import sbp_pkg::*;
(
    input  logic [BEATS*DATA_W-1:0]  words,
    output logic [DATA_W-1:0]        header,
    output logic [SUBPKTS*SUB_W-1:0] subs
);
    assign header = words[DATA_W-1:0];

    for (genvar k = 0; k < SUBPKTS; k++) begin : g_sub
        for (genvar j = 0; j < BEATS_PER_SUB; j++) begin : g_half
            assign subs[k*SUB_W + j*DATA_W +: DATA_W] =
                words[(1 + k*BEATS_PER_SUB + j)*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/sbp_bridge.sv
// Module: sbp_bridge (top)
// Stream slave -> FIFO -> packet assembler -> valid/ready packet output.
// Assumes the source holds data and tvalid stable while tready is low.
module sbp_bridge
    import sbp_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] s_tdata,
    input  logic        s_tvalid,
    input  logic        s_tlast,
    output logic        s_tready,
    output logic        pkt_valid,
    input  logic        pkt_ready,
    output logic [31:0] pkt_header,
    output logic [63:0] pkt_sub0,
    output logic [63:0] pkt_sub1,
    output logic [63:0] pkt_sub2,
    output logic [63:0] pkt_sub3,
    output logic        frame_err
);
    localparam int FW = DATA_W + 1;

    logic                     fifo_full;
    logic                     fifo_empty;
    logic [FW-1:0]            head;
    logic                     beat_take;
    logic [BEATS*DATA_W-1:0]  words;
    logic [SUBPKTS*SUB_W-1:0] subs;

    // Ready whenever the buffer has space.
    assign s_tready = !fifo_full;

    sbp_fifo #(.WIDTH(FW), .DEPTH(DEPTH)) fifo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (s_tvalid),
        .wr_data ({s_tlast, s_tdata}),
        .full    (fifo_full),
        .rd_en   (beat_take),
        .rd_data (head),
        .empty   (fifo_empty)
    );

    sbp_assembler asm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_avail (!fifo_empty),
        .beat_data  (head[DATA_W-1:0]),
        .beat_last  (head[DATA_W]),
        .beat_take  (beat_take),
        .pkt_valid  (pkt_valid),
        .pkt_ready  (pkt_ready),
        .frame_err  (frame_err),
        .words      (words)
    );

    sbp_packer pack_i (
        .words  (words),
        .header (pkt_header),
        .subs   (subs)
    );

    assign pkt_sub0 = subs[0*SUB_W +: SUB_W];
    assign pkt_sub1 = subs[1*SUB_W +: SUB_W];
    assign pkt_sub2 = subs[2*SUB_W +: SUB_W];
    assign pkt_sub3 = subs[3*SUB_W +: SUB_W];
endmodule

// File: rtl/sbp_bridge_chk.sv
// Module: sbp_bridge_chk
// Cycle-by-cycle properties of the bridge. It keeps its own occupancy
// count from the stream handshake and the assembler's pop strobe.
module sbp_bridge_chk #(
    parameter int DEPTH = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        s_tvalid,
    input logic        s_tready,
    input logic        pop,
    input logic        pkt_valid,
    input logic        pkt_ready,
    input logic        frame_err,
    input logic [31:0] pkt_header,
    input logic [63:0] pkt_sub0,
    input logic [63:0] pkt_sub1,
    input logic [63:0] pkt_sub2,
    input logic [63:0] pkt_sub3
);
    int occ;

    // Independent occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) occ <= 0;
        else        occ <= occ + int'(s_tvalid && s_tready) - int'(pop);
    end

    // R1
    ready_tracks_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_tready == (occ < DEPTH));

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= DEPTH);

    // R2
    no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> occ > 0);

    // R5
    pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_header)
            && $stable(pkt_sub0) && $stable(pkt_sub1)
            && $stable(pkt_sub2) && $stable(pkt_sub3)));

    // R5
    no_pop_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> !pop);

    // R6
    err_not_with_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pkt_valid) |-> !frame_err);
endmodule

bind sbp_bridge sbp_bridge_chk #(.DEPTH(DEPTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_tvalid   (s_tvalid),
    .s_tready   (s_tready),
    .pop        (beat_take),
    .pkt_valid  (pkt_valid),
    .pkt_ready  (pkt_ready),
    .frame_err  (frame_err),
    .pkt_header (pkt_header),
    .pkt_sub0   (pkt_sub0),
    .pkt_sub1   (pkt_sub1),
    .pkt_sub2   (pkt_sub2),
    .pkt_sub3   (pkt_sub3)
);

// File: tb/sbp_bridge_tb_top.sv
// Bench: behavioural reference model (queue + counters), compared with the
// design on every falling edge. Inputs are driven on falling edges.
module sbp_bridge_tb_top;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] s_tdata = '0;
    logic        s_tvalid = 1'b0;
    logic        s_tlast = 1'b0;
    logic        s_tready;
    logic        pkt_valid;
    logic        pkt_ready;
    logic [31:0] pkt_header;
    logic [63:0] pkt_sub0, pkt_sub1, pkt_sub2, pkt_sub3;
    logic        frame_err;

    always #10 clk = ~clk;   // 50 MHz

    sbp_bridge #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
        .s_tlast(s_tlast), .s_tready(s_tready), .pkt_valid(pkt_valid),
        .pkt_ready(pkt_ready), .pkt_header(pkt_header), .pkt_sub0(pkt_sub0),
        .pkt_sub1(pkt_sub1), .pkt_sub2(pkt_sub2), .pkt_sub3(pkt_sub3),
        .frame_err(frame_err)
    );

    int checks = 0;
    int errors = 0;
    int ready_mode = 0;      // 0: always ready, 1: never, 2: pseudo-random
    logic [7:0] lf = 8'h5B;
    bit model_on = 0;

    // Reference model state.
    logic [32:0] mq[$];
    logic [31:0] mbuf[9];
    int          mcnt = 0;
    bit          mdrain = 0;
    bit          ev = 0;
    bit          eerr = 0;
    logic [31:0] eh;
    logic [63:0] es[4];
    int          err_seen = 0;
    int          pkt_seen = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Downstream ready driver.
    always @(negedge clk) begin
        lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        case (ready_mode)
            0:       pkt_ready <= 1'b1;
            1:       pkt_ready <= 1'b0;
            default: pkt_ready <= lf[0];
        endcase
    end

    // Model advance on each rising edge from pre-edge values.
    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); mcnt = 0; mdrain = 0; ev = 0; eerr = 0;
        end else begin
            bit pop, acc;
            logic [32:0] b;
            pop = (mq.size() > 0) && !ev;
            acc = s_tvalid && (mq.size() < DEPTH);
            if (pkt_valid && pkt_ready) pkt_seen++;
            if (frame_err) err_seen++;
            eerr = 0;
            if (ev && pkt_ready) ev = 0;
            if (pop) begin
                b = mq.pop_front();
                if (mdrain) begin
                    if (b[32]) mdrain = 0;
                end else if (b[32]) begin
                    if (mcnt == 8) begin
                        mbuf[8] = b[31:0];
                        eh = mbuf[0];
                        for (int k = 0; k < 4; k++) es[k] = {mbuf[2*k+2], mbuf[2*k+1]};
                        ev = 1;
                    end else eerr = 1;
                    mcnt = 0;
                end else if (mcnt == 8) begin
                    eerr = 1; mcnt = 0; mdrain = 1;
                end else begin
                    mbuf[mcnt] = b[31:0]; mcnt++;
                end
            end
            if (acc) mq.push_back({s_tlast, s_tdata});
        end
    end

    // Per-cycle comparison.
    always @(negedge clk) begin
        if (model_on) begin
            chk(s_tready == (mq.size() < DEPTH), "R1 tready", 64'(s_tready), 64'(mq.size() < DEPTH));
            chk(pkt_valid == ev, "R5 pkt_valid", 64'(pkt_valid), 64'(ev));
            chk(frame_err == eerr, "R6/R7 frame_err", 64'(frame_err), 64'(eerr));
            if (ev && pkt_valid) begin
                chk(pkt_header == eh, "R3 header", 64'(pkt_header), 64'(eh));
                chk(pkt_sub0 == es[0], "R4 sub0", pkt_sub0, es[0]);
                chk(pkt_sub1 == es[1], "R4 sub1", pkt_sub1, es[1]);
                chk(pkt_sub2 == es[2], "R4 sub2", pkt_sub2, es[2]);
                chk(pkt_sub3 == es[3], "R4 sub3", pkt_sub3, es[3]);
            end
        end
    end

    function automatic logic [31:0] bw(input int p, input int b);
        return {p[7:0] ^ 8'h3C, 8'(b * 37), p[7:0], 8'(b) | 8'hA0};
    endfunction

    // Drive one beat; call right after a falling edge.
    task automatic send(input logic [31:0] d, input bit l);
        s_tdata = d; s_tlast = l; s_tvalid = 1'b1;
        while (!s_tready) @(negedge clk);
        @(negedge clk);
        s_tvalid = 1'b0;
    endtask

    task automatic send_pkt(input int p, input int n, input int last_at, input int gap);
        for (int b = 0; b < n; b++) begin
            send(bw(p, b), b == last_at);
            repeat (gap) @(negedge clk);
        end
    endtask

    initial begin
        int e0, p0;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(!pkt_valid, "R8 pkt_valid after reset", 64'(pkt_valid), 0);
        chk(!frame_err, "R8 frame_err after reset", 64'(frame_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(s_tready, "R8 tready after reset", 64'(s_tready), 1);
        model_on = 1;

        // R3 R4: back-to-back packets, always ready
        for (int p = 1; p <= 3; p++) send_pkt(p, 9, 8, 0);
        repeat (20) @(negedge clk);
        chk(pkt_seen == 3, "R3 packets delivered", 64'(pkt_seen), 3);

        // R5 R1: stall downstream, then fill the FIFO
        ready_mode = 1;
        send_pkt(10, 9, 8, 0);
        send_pkt(11, 9, 8, 0);
        for (int b = 0; b < 7; b++) send(bw(12, b), 1'b0);
        @(negedge clk);
        chk(!s_tready, "R1 tready low when full", 64'(s_tready), 0);
        chk(pkt_valid, "R5 packet pending while stalled", 64'(pkt_valid), 1);
        ready_mode = 0;
        send(bw(12, 7), 1'b0);
        send(bw(12, 8), 1'b1);
        repeat (40) @(negedge clk);
        chk(pkt_seen == 6, "R5 all stalled packets delivered", 64'(pkt_seen), 6);

        // R6: early tlast on beat 4, then a clean packet
        e0 = err_seen; p0 = pkt_seen;
        send_pkt(20, 4, 3, 0);
        send_pkt(21, 9, 8, 0);
        repeat (20) @(negedge clk);
        chk(err_seen == e0 + 1, "R6 one error pulse", 64'(err_seen), 64'(e0 + 1));
        chk(pkt_seen == p0 + 1, "R6 resync packet", 64'(pkt_seen), 64'(p0 + 1));

        // R7: ninth beat without tlast, junk up to tlast, then clean packet
        e0 = err_seen; p0 = pkt_seen;
        send_pkt(30, 9, 99, 0);
        send_pkt(31, 3, 2, 0);
        send_pkt(32, 9, 8, 0);
        repeat (20) @(negedge clk);
        chk(err_seen == e0 + 1, "R7 one error pulse", 64'(err_seen), 64'(e0 + 1));
        chk(pkt_seen == p0 + 1, "R7 resync packet", 64'(pkt_seen), 64'(p0 + 1));

        // R2: gaps on tvalid with random downstream ready
        ready_mode = 2;
        p0 = pkt_seen;
        for (int p = 40; p < 46; p++) send_pkt(p, 9, 8, p % 3);
        ready_mode = 0;
        repeat (40) @(negedge clk);
        chk(pkt_seen == p0 + 6, "R2 packets with gaps", 64'(pkt_seen), 64'(p0 + 6));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule